// File: doc/BRIEF.md
# Dual-Target Level Interrupt Controller

This block gathers 32 level-sensitive interrupt request lines and presents them to two processors. Every processor (target) owns a private pair of registers: a cause register that records which lines have been seen high, and a mask register that selects which of those lines may raise that target's interrupt output. The same lines feed both pairs. Any line can therefore be steered to one processor, the other, both or neither, purely by how software sets the two masks.

A cause bit is set in every cycle its line is high, whatever the mask says. Masked requests stay visible to software that polls the cause register. Software retires a request by writing a one to its cause bit. Because sources are level-sensitive, a line that is still high sets its bit again at once. Each interrupt output is the OR over the bits that are set in both the cause and the mask register of its target.

Software reaches the registers over a simple synchronous bus: byte address, write strobe, 32-bit write data, and a registered 32-bit read result one cycle after the address is presented.

Top module: `dual_lvl_intc`

## Requirements
- R1: After reset, both cause registers and both mask registers are zero and both bits of `irq_out` are 0.
- R2: A source line that is high at a clock edge sets its cause bit in every target from that edge on, whatever the mask bit is.
- R3: Writing a cause register clears each bit written as one, provided its source is low in that cycle. Bits written as zero keep their value.
- R4: When a source is high in the same cycle that its cause bit is written with a one, the bit stays set.
- R5: Each mask register holds exactly the last value written to it and changes on no other event.
- R6: `irq_out[t]` is 1 exactly when target t's cause AND mask is non-zero. It follows the registers with no extra delay.
- R7: The two targets are independent. With a line enabled in both masks, both outputs assert. Clearing the line's mask bit in one target drops only that target's output.
- R8: Register map by byte address: 0x00 target 0 cause, 0x04 target 0 mask, 0x08 target 1 cause, 0x0C target 1 mask. `bus_rdata` shows the addressed register one cycle after the address is presented.
- R9: Any other address (including 0x01 to 0x03 and 0x10 and above) reads as zero, and a write to it changes no register.
- R10: With all sources low, writing 0 to a target's mask and then 0xFFFFFFFF to its cause leaves that target with cause zero and its output at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | 32 | Level-sensitive request lines, bit i is source i |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, one cycle after the address |
| irq_out | output | 2 | Interrupt output, bit t for target t |

## Verification
Single lines are raised with their mask open and closed. This separates latching, which never depends on the mask, from output gating, which does. An acknowledge is issued once with the line already low and once while it is still high; this tells a plain clear apart from the set-over-clear rule. A mixed pattern of ones and zeros written to a cause register with several bits set shows that zero bits are left alone. One line enabled in both masks, followed by closing one mask, separates the two targets. The shutdown sequence and writes to unmapped and misaligned addresses check that nothing outside the four registers can be touched.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC    = 32;
  localparam int NUM_TGT = 2;
  localparam int ADDR_W  = 8;
  localparam int TGT_W   = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;

  typedef logic [NSRC-1:0] vec_t;

  // next value of a cause register: write-one clears, live level sets (set wins)
  function automatic vec_t cause_next(vec_t cur, vec_t lvl, logic ack_en, vec_t wdata);
    vec_t ack;
    ack = ack_en ? wdata : '0;
    return (cur & ~ack) | lvl;
  endfunction

  // any request both latched and enabled
  function automatic logic any_pending(vec_t cause, vec_t mask);
    return |(cause & mask);
  endfunction
endpackage

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  vec_t src_lvl,
  input  logic cause_we,
  input  logic mask_we,
  input  vec_t wdata,
  output vec_t cause_q,
  output vec_t mask_q,
  output logic irq
);
  vec_t pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      cause_q <= cause_next(cause_q, src_lvl, cause_we, wdata);
      if (mask_we) mask_q <= wdata;
    end
  end

  assign pend = cause_q & mask_q;
  assign irq  = any_pending(cause_q, mask_q);

  AST_LEVEL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & $past(src_lvl)) == $past(src_lvl))); // R2
  AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    cause_we |=> ((cause_q & $past(wdata) & $past(src_lvl)) == ($past(wdata) & $past(src_lvl)))); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cause_we |=> ((cause_q & $past(wdata) & ~$past(src_lvl)) == '0)); // R3
  AST_NO_ACK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_we |=> (($past(cause_q) & ~cause_q) == '0)); // R3
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q)); // R5
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(wdata))); // R5
  AST_CLOSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq); // R6
  AST_PEND_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |-> irq); // R6
endmodule

// File: rtl/irqc_regdec.sv
module irqc_regdec
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  vec_t              cause_rd [NUM_TGT],
  input  vec_t              mask_rd  [NUM_TGT],
  output logic [NUM_TGT-1:0] cause_we,
  output logic [NUM_TGT-1:0] mask_we,
  output vec_t              rdata
);
  localparam int HI_LSB = 3 + TGT_W;

  logic             hit;
  logic             sel_mask;
  logic [TGT_W-1:0] tgt;
  vec_t             rd_d;

  assign tgt      = addr[3 +: TGT_W];
  assign sel_mask = addr[2];

  generate
    if (HI_LSB < ADDR_W) begin : g_hi
      assign hit = (addr[ADDR_W-1:HI_LSB] == '0) && (addr[1:0] == 2'b00)
                   && (int'(tgt) < NUM_TGT);
    end else begin : g_nohi
      assign hit = (addr[1:0] == 2'b00) && (int'(tgt) < NUM_TGT);
    end
  endgenerate

  generate
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_we
      assign cause_we[t] = we && hit && (int'(tgt) == t) && !sel_mask;
      assign mask_we[t]  = we && hit && (int'(tgt) == t) &&  sel_mask;
    end
  endgenerate

  always_comb begin
    rd_d = '0;
    for (int t = 0; t < NUM_TGT; t++) begin
      if (hit && int'(tgt) == t) rd_d = sel_mask ? mask_rd[t] : cause_rd[t];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_d;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> (rdata == '0)); // R9
  AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> ((cause_we == '0) && (mask_we == '0))); // R9
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cause_we, mask_we})); // R8
endmodule

// File: rtl/dual_lvl_intc.sv
module dual_lvl_intc
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_lvl,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  output logic [NUM_TGT-1:0] irq_out
);
  vec_t               cause_v [NUM_TGT];
  vec_t               mask_v  [NUM_TGT];
  logic [NUM_TGT-1:0] cause_we;
  logic [NUM_TGT-1:0] mask_we;

  irqc_regdec u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .we       (bus_we),
    .cause_rd (cause_v),
    .mask_rd  (mask_v),
    .cause_we (cause_we),
    .mask_we  (mask_we),
    .rdata    (bus_rdata)
  );

  generate
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
      irqc_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_lvl  (src_lvl),
        .cause_we (cause_we[t]),
        .mask_we  (mask_we[t]),
        .wdata    (bus_wdata),
        .cause_q  (cause_v[t]),
        .mask_q   (mask_v[t]),
        .irq      (irq_out[t])
      );
    end
  endgenerate

  AST_SHARED_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_v[0] & $past(src_lvl)) == (cause_v[1] & $past(src_lvl)))); // R7
endmodule

// File: tb/sim_dual_lvl_intc.sv
module sim_dual_lvl_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_lvl = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_out;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dual_lvl_intc u0 (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  localparam logic [7:0] A_C0 = 8'h00, A_M0 = 8'h04, A_C1 = 8'h08, A_M1 = 8'h0C;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse_src(logic [31:0] v);
    @(negedge clk); src_lvl = v;
    @(negedge clk); src_lvl = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {30'd0, irq_out}, 32'd0);
    rd(A_C0, d); check("R1 cause0", d, 0);
    rd(A_M0, d); check("R1 mask0", d, 0);
    rd(A_C1, d); check("R1 cause1", d, 0);
    rd(A_M1, d); check("R1 mask1", d, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(A_M0, 32'hA5A5_0000); wr(A_M1, 32'h0000_5A5A);
    rd(A_M0, d); check("R8 R5 mask0", d, 32'hA5A5_0000);
    rd(A_M1, d); check("R8 R5 mask1", d, 32'h0000_5A5A);
    wr(A_M0, 0); wr(A_M1, 0);
    rd(A_M0, d); check("R5 mask0 clr", d, 0);
  endtask

  task automatic t_latch_masked();
    logic [31:0] d;
    pulse_src(32'h0000_0010);
    @(negedge clk);
    check("R2 R6 masked irq", {30'd0, irq_out}, 0);
    rd(A_C0, d); check("R2 cause0", d, 32'h10);
    rd(A_C1, d); check("R2 cause1", d, 32'h10);
    wr(A_M0, 32'h10);
    @(negedge clk);
    check("R6 irq0 open", {30'd0, irq_out}, 32'd1);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    pulse_src(32'h8000_0101);
    wr(A_C0, 32'h0000_0110);
    rd(A_C0, d); check("R3 partial ack", d, 32'h8000_0001);
    @(negedge clk);
    check("R6 irq0 after ack", {30'd0, irq_out}, 32'd0);
    rd(A_C1, d); check("R3 other target", d, 32'h8000_0111);
    wr(A_C0, 32'hFFFF_FFFF); wr(A_C1, 32'hFFFF_FFFF);
    rd(A_C1, d); check("R3 full ack", d, 0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    @(negedge clk); src_lvl = 32'h20;
    @(negedge clk);
    bus_addr = A_C0; bus_wdata = 32'h20; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; src_lvl = '0;
    rd(A_C0, d); check("R4 held", d, 32'h20);
    wr(A_C0, 32'h20);
    rd(A_C0, d); check("R4 clears when low", d, 0);
    wr(A_C1, 32'hFFFF_FFFF);
  endtask

  task automatic t_two_targets();
    pulse_src(32'h200);
    wr(A_M0, 32'h200); wr(A_M1, 32'h200);
    @(negedge clk);
    check("R7 both", {30'd0, irq_out}, 32'd3);
    wr(A_M0, 0);
    @(negedge clk);
    check("R7 t1 only", {30'd0, irq_out}, 32'd2);
    wr(A_M0, 32'h200); wr(A_M1, 0);
    @(negedge clk);
    check("R7 t0 only", {30'd0, irq_out}, 32'd1);
  endtask

  task automatic t_quiesce();
    logic [31:0] d;
    pulse_src(32'h0F0F_0000);
    wr(A_M0, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R10 pre", {31'd0, irq_out[0]}, 1);
    wr(A_M0, 0); wr(A_C0, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R10 irq0", {31'd0, irq_out[0]}, 0);
    rd(A_C0, d); check("R10 cause0", d, 0);
    rd(A_C1, d); check("R10 cause1 untouched", d, 32'h0F0F_0200);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h06, 32'hFFFF_FFFF); wr(8'h89, 32'hFFFF_FFFF);
    rd(8'h10, d); check("R9 read 0x10", d, 0);
    rd(8'h02, d); check("R9 read 0x02", d, 0);
    rd(A_M0, d); check("R9 mask0 kept", d, 0);
    rd(A_M1, d); check("R9 mask1 kept", d, 0);
    rd(A_C1, d); check("R9 cause1 kept", d, 32'h0F0F_0200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_latch_masked();
    t_ack();
    t_set_wins();
    t_two_targets();
    wr(A_M0, 0); wr(A_C0, 32'hFFFF_FFFF);
    t_quiesce();
    t_unmapped();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule